// File: doc/BRIEF.md
# Audio Channel Word FIFO with Programmable Watermarks

This block is one channel of a multi-channel audio buffer. It stores 32-bit sample words in a 512-entry queue and comes in two flavours chosen by a parameter. In the capture flavour a converter pushes words in through a valid/ready stream and software drains them by reading a data port on the bus. In the playback flavour software fills the queue through bus writes and a converter drains it through a valid/ready stream.

Software programs two 9-bit thresholds in one watermark register. From them and the fill level the block derives four status flags: queue completely full, queue completely empty, level at or above the upper threshold, and level at or below the lower threshold. Both raw pointers are published in a status word, so software can compute free space or stored data without a counter register. A synchronous clear empties the queue, and a sticky overflow flag records any word that was lost because the queue was full.

Back-pressure: on the converter input stream `s_ready` is high whenever the capture queue has room, but the converter is not expected to wait. A beat offered with `s_ready` low is lost and sets the overflow flag. On the converter output stream `m_valid` is high whenever the playback queue holds a word, and a word leaves on each cycle where `m_valid` and `m_ready` are both high.

Top module: `afifo_chan`

## Requirements
- R1: After reset the pointers are zero, the flags word is 4'b1010 (empty and almost empty), overflow is low, and the watermark register reads 0x000001FF (upper threshold 511, lower threshold 0).
- R2: Words leave the queue in the order they entered it, including when the storage address wraps past entry 511.
- R3: A push while the queue holds 512 words is dropped and leaves the write pointer unchanged. It also sets the overflow flag, which stays high until a clear.
- R4: A pop while the queue is empty leaves the read pointer unchanged. In capture the bus read data returned for it is zero.
- R5: The flags word has bit 0 full (level 512) and bit 1 empty (level 0). The two are never high together.
- R6: Flags bit 2 is high exactly when the fill level is at or above the upper threshold, held in watermark bits 8:0.
- R7: Flags bit 3 is high exactly when the fill level is at or below the lower threshold, held in watermark bits 24:16. Other written watermark bits read back as zero.
- R8: The status word holds the 10-bit read pointer in bits 25:16 and the 10-bit write pointer in bits 9:0. The fill level is (write − read) modulo 1024 and never exceeds 512.
- R9: A clear makes both pointers zero and lowers overflow on the next cycle, and it keeps the watermark register.
- R10: Capture ignores bus writes and keeps `m_valid` low. Playback ignores the input stream, keeps `s_ready` low, and returns zero on bus reads.
- R11: In playback, `m_valid` equals "not empty" and `m_data` shows the oldest word. A handshake advances to the next word.
- R12: In capture, bus read data appears on the cycle after `bus_rd_en` and is the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous queue clear |
| wmark_we | input | 1 | Watermark register write strobe |
| wmark_wdata | input | 32 | Watermark write value |
| wmark_q | output | 32 | Watermark register readback |
| s_valid | input | 1 | Converter input beat valid (capture) |
| s_ready | output | 1 | Room available for a converter beat |
| s_data | input | 32 | Converter input word |
| bus_wr_en | input | 1 | Bus data write strobe (playback) |
| bus_wr_data | input | 32 | Bus data write word |
| bus_rd_en | input | 1 | Bus data read strobe (capture) |
| bus_rd_data | output | 32 | Bus data read word, one cycle after the strobe |
| m_valid | output | 1 | Converter output word valid (playback) |
| m_ready | input | 1 | Converter accepts the output word |
| m_data | output | 32 | Converter output word |
| fifo_flags | output | 4 | {almost empty, almost full, empty, full} |
| ptr_status | output | 32 | Read pointer in 25:16, write pointer in 9:0 |
| overflow | output | 1 | Sticky lost-word flag |

## Verification
The checker assumes that reset is asserted before the first checked edge, and that the pointers only ever move through the block's own admission logic. Under that assumption the level computed from the status word can never exceed the depth, and a held pointer on full or empty is a real property. The bench stays inside this by driving every input on a fixed offset after the clock edge and never forcing internal state. It also exercises the flavour-specific inputs of each instance with legal one-cycle strobes only. Watermark writes carry junk in the unused bits so that masking is exercised without ever putting an out-of-range threshold into the 9-bit fields.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  typedef enum logic {
    DIR_CAPTURE  = 1'b0,
    DIR_PLAYBACK = 1'b1
  } afifo_dir_e;

  // bit order of the flags word is decoded by software
  typedef struct packed {
    logic aempty;   // bit 3
    logic afull;    // bit 2
    logic empty;    // bit 1
    logic full;     // bit 0
  } afifo_flags_t;

  localparam int unsigned WM_AF_LSB = 0;
  localparam int unsigned WM_AE_LSB = 16;
  localparam int unsigned PS_WR_LSB = 0;
  localparam int unsigned PS_RD_LSB = 16;

endpackage

// File: rtl/afifo_ptr.sv
module afifo_ptr #(
  parameter int unsigned PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
    end
  end

endmodule

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/afifo_level.sv
module afifo_level
  import afifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic [PW-1:0] wptr,
  input  logic [PW-1:0] rptr,
  input  logic [AW-1:0] af_thr,
  input  logic [AW-1:0] ae_thr,
  output afifo_flags_t  flags
);

  logic [PW-1:0] level;

  always_comb begin
    level        = wptr - rptr;
    flags.full   = (level == PW'(DEPTH));
    flags.empty  = (level == '0);
    flags.afull  = (level >= {1'b0, af_thr});
    flags.aempty = (level <= {1'b0, ae_thr});
  end

endmodule

// File: rtl/afifo_wmark.sv
module afifo_wmark
  import afifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic [AW-1:0] af_thr,
  output logic [AW-1:0] ae_thr,
  output logic [31:0]   wmark_q
);

  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:WM_AE_LSB+AW], wdata[WM_AE_LSB-1:WM_AF_LSB+AW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      af_thr <= AW'(DEPTH - 1);
      ae_thr <= '0;
    end else if (we) begin
      af_thr <= wdata[WM_AF_LSB +: AW];
      ae_thr <= wdata[WM_AE_LSB +: AW];
    end
  end

  assign wmark_q = (32'(af_thr) << WM_AF_LSB) | (32'(ae_thr) << WM_AE_LSB);

endmodule

// File: rtl/afifo_chan.sv
module afifo_chan
  import afifo_pkg::*;
#(
  parameter afifo_dir_e  DIR   = DIR_CAPTURE,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wmark_we,
  input  logic [31:0]   wmark_wdata,
  output logic [31:0]   wmark_q,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_wr_data,
  input  logic          bus_rd_en,
  output logic [DW-1:0] bus_rd_data,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data,
  output logic [3:0]    fifo_flags,
  output logic [31:0]   ptr_status,
  output logic          overflow
);

  localparam bit IS_PLAY = (DIR == DIR_PLAYBACK);

  logic          push_req, pop_req, push_ok, push_drop, pop_ok;
  logic [DW-1:0] push_data, head;
  logic [PW-1:0] wptr, rptr;
  logic [AW-1:0] af_thr, ae_thr;
  afifo_flags_t  flags;

  generate
    if (IS_PLAY) begin : g_play
      logic unused_play;
      assign unused_play = ^{s_valid, s_data, bus_rd_en};
      assign push_req  = bus_wr_en;
      assign push_data = bus_wr_data;
      assign pop_req   = m_ready;
      assign s_ready   = 1'b0;
      assign m_valid   = !flags.empty;
      assign m_data    = flags.empty ? '0 : head;
    end else begin : g_cap
      logic unused_cap;
      assign unused_cap = ^{bus_wr_en, bus_wr_data, m_ready};
      assign push_req  = s_valid;
      assign push_data = s_data;
      assign pop_req   = bus_rd_en;
      assign s_ready   = !flags.full;
      assign m_valid   = 1'b0;
      assign m_data    = '0;
    end
  endgenerate

  // admission: fullness is judged before any same-cycle pop
  assign push_ok   = push_req && !flags.full  && !clr;
  assign push_drop = push_req &&  flags.full  && !clr;
  assign pop_ok    = pop_req  && !flags.empty && !clr;

  afifo_ptr #(.PW(PW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(push_ok), .pop(pop_ok),
    .wptr(wptr), .rptr(rptr)
  );

  afifo_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(push_ok), .waddr(wptr[AW-1:0]), .wdata(push_data),
    .raddr(rptr[AW-1:0]), .rdata(head)
  );

  afifo_wmark #(.DEPTH(DEPTH)) u_wmark (
    .clk(clk), .rst_n(rst_n), .we(wmark_we), .wdata(wmark_wdata),
    .af_thr(af_thr), .ae_thr(ae_thr), .wmark_q(wmark_q)
  );

  afifo_level #(.DEPTH(DEPTH)) u_level (
    .wptr(wptr), .rptr(rptr), .af_thr(af_thr), .ae_thr(ae_thr), .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (clr)       overflow <= 1'b0;
    else if (push_drop) overflow <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rd_data <= '0;
    else if (!IS_PLAY && pop_ok) bus_rd_data <= head;
    else                         bus_rd_data <= '0;
  end

  assign fifo_flags = flags;
  assign ptr_status = (32'(rptr) << PS_RD_LSB) | (32'(wptr) << PS_WR_LSB);

endmodule

// File: rtl/afifo_chan_chk.sv
module afifo_chan_chk #(
  parameter int unsigned DEPTH = 512,
  parameter bit          PLAY  = 1'b0,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clr,
  input logic        s_valid,
  input logic        s_ready,
  input logic        bus_wr_en,
  input logic        bus_rd_en,
  input logic        m_valid,
  input logic [3:0]  fifo_flags,
  input logic [31:0] ptr_status,
  input logic [31:0] wmark_q,
  input logic        overflow
);

  logic [PW-1:0] wr_f, rd_f, lvl;
  logic [AW-1:0] af_t, ae_t;
  logic          unused_chk;

  assign wr_f = ptr_status[0 +: PW];
  assign rd_f = ptr_status[16 +: PW];
  assign lvl  = wr_f - rd_f;
  assign af_t = wmark_q[0 +: AW];
  assign ae_t = wmark_q[16 +: AW];
  assign unused_chk = ^{ptr_status, wmark_q, s_valid, bus_wr_en, bus_rd_en};

  assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_flags[0] && fifo_flags[1]));

  assert_no_overflow_lost_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !clr) |=> overflow);

  assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flags[0] && !clr) |=> (ptr_status[0 +: PW] == $past(wr_f)));

  assert_empty_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flags[1] && !clr) |=> (ptr_status[16 +: PW] == $past(rd_f)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_status == 32'h0 && fifo_flags[1] && !overflow));

  assert_level_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= PW'(DEPTH));

  assert_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flags[2] == (lvl >= {1'b0, af_t}));

  assert_aempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flags[3] == (lvl <= {1'b0, ae_t}));

  assert_mvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid == (PLAY && !fifo_flags[1]));

  assert_sready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready == (!PLAY && !fifo_flags[0]));

endmodule

bind afifo_chan afifo_chan_chk #(
  .DEPTH(DEPTH),
  .PLAY(DIR == afifo_pkg::DIR_PLAYBACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .s_valid(s_valid), .s_ready(s_ready),
  .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .m_valid(m_valid), .fifo_flags(fifo_flags),
  .ptr_status(ptr_status), .wmark_q(wmark_q), .overflow(overflow)
);

// File: tb/test_afifo_chan.sv
module test_afifo_chan;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // capture instance signals
  logic        c_clr = 0, c_wme = 0, c_sv = 0, c_bwe = 0, c_bre = 0, c_mr = 0;
  logic [31:0] c_wmd = 0, c_sd = 0, c_bwd = 0;
  logic [31:0] c_wmq, c_brd, c_md, c_ps;
  logic        c_sr, c_mv, c_ovf;
  logic [3:0]  c_fl;

  // playback instance signals
  logic        p_clr = 0, p_wme = 0, p_sv = 0, p_bwe = 0, p_bre = 0, p_mr = 0;
  logic [31:0] p_wmd = 0, p_sd = 0, p_bwd = 0;
  logic [31:0] p_wmq, p_brd, p_md, p_ps;
  logic        p_sr, p_mv, p_ovf;
  logic [3:0]  p_fl;

  afifo_chan #(.DIR(afifo_pkg::DIR_CAPTURE)) i_afifo_chan (
    .clk(clk), .rst_n(rst_n), .clr(c_clr),
    .wmark_we(c_wme), .wmark_wdata(c_wmd), .wmark_q(c_wmq),
    .s_valid(c_sv), .s_ready(c_sr), .s_data(c_sd),
    .bus_wr_en(c_bwe), .bus_wr_data(c_bwd),
    .bus_rd_en(c_bre), .bus_rd_data(c_brd),
    .m_valid(c_mv), .m_ready(c_mr), .m_data(c_md),
    .fifo_flags(c_fl), .ptr_status(c_ps), .overflow(c_ovf)
  );

  afifo_chan #(.DIR(afifo_pkg::DIR_PLAYBACK)) i_afifo_chan_play (
    .clk(clk), .rst_n(rst_n), .clr(p_clr),
    .wmark_we(p_wme), .wmark_wdata(p_wmd), .wmark_q(p_wmq),
    .s_valid(p_sv), .s_ready(p_sr), .s_data(p_sd),
    .bus_wr_en(p_bwe), .bus_wr_data(p_bwd),
    .bus_rd_en(p_bre), .bus_rd_data(p_brd),
    .m_valid(p_mv), .m_ready(p_mr), .m_data(p_md),
    .fifo_flags(p_fl), .ptr_status(p_ps), .overflow(p_ovf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // inputs change 1 ns after an edge; results are sampled there too
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA500_0000 + 32'(i) * 32'd3;
  endfunction

  task automatic t_reset();
    check("R1 cap flags", {28'h0, c_fl}, 32'hA);
    check("R1 cap ptrs", c_ps, 32'h0);
    check("R1 cap ovf", {31'h0, c_ovf}, 32'h0);
    check("R1 cap wmark", c_wmq, 32'h0000_01FF);
    check("R1 play flags", {28'h0, p_fl}, 32'hA);
    check("R10 play s_ready low", {31'h0, p_sr}, 32'h0);
    check("R11 play m_valid low when empty", {31'h0, p_mv}, 32'h0);
  endtask

  task automatic t_fill_overflow();
    for (int i = 0; i < 511; i++) begin
      c_sv = 1; c_sd = pat(i); tick();
    end
    check("R6 level 511 at default upper threshold", {28'h0, c_fl}, 32'h4);
    c_sd = pat(511); tick();
    check("R5 full at 512", {28'h0, c_fl}, 32'h5);
    check("R8 ptrs at full", c_ps, 32'h0000_0200);
    check("R3 ovf still low", {31'h0, c_ovf}, 32'h0);
    check("R3 s_ready low when full", {31'h0, c_sr}, 32'h0);
    c_sd = 32'hDEAD_BEEF; tick();
    c_sv = 0;
    check("R3 ovf set by dropped push", {31'h0, c_ovf}, 32'h1);
    check("R3 write pointer held", c_ps, 32'h0000_0200);
  endtask

  task automatic t_drain();
    int errs = 0;
    for (int i = 0; i < 512; i++) begin
      c_bre = 1; tick();
      if (c_brd !== pat(i)) errs++;
    end
    c_bre = 0;
    check("R12 R2 read order and latency", 32'(errs), 32'h0);
    check("R5 empty after drain", {28'h0, c_fl}, 32'hA);
    check("R8 ptrs after drain", c_ps, 32'h0200_0200);
    check("R3 ovf sticky", {31'h0, c_ovf}, 32'h1);
  endtask

  task automatic t_empty_read();
    c_bre = 1; tick(); c_bre = 0;
    check("R4 empty read data zero", c_brd, 32'h0);
    check("R4 read pointer held", c_ps, 32'h0200_0200);
  endtask

  task automatic t_clear();
    c_wme = 1; c_wmd = 32'hFE04_FE06; tick(); c_wme = 0;
    check("R7 watermark masking", c_wmq, 32'h0004_0006);
    c_clr = 1; tick(); c_clr = 0;
    check("R9 ptrs cleared", c_ps, 32'h0);
    check("R9 ovf cleared", {31'h0, c_ovf}, 32'h0);
    check("R9 watermark kept", c_wmq, 32'h0004_0006);
  endtask

  task automatic t_thresholds();
    for (int i = 0; i < 4; i++) begin
      c_sv = 1; c_sd = pat(i); tick();
    end
    c_sv = 0;
    check("R7 level 4 at lower threshold 4", {28'h0, c_fl}, 32'h8);
    c_sv = 1; tick(); c_sv = 0;
    check("R7 R6 level 5 between thresholds", {28'h0, c_fl}, 32'h0);
    c_sv = 1; tick(); c_sv = 0;
    check("R6 level 6 at upper threshold 6", {28'h0, c_fl}, 32'h4);
  endtask

  task automatic t_cap_ignore();
    c_bwe = 1; c_bwd = 32'h1234_5678; tick(); c_bwe = 0;
    check("R10 capture ignores bus write", c_ps, 32'h0000_0006);
    check("R10 capture m_valid low", {31'h0, c_mv}, 32'h0);
  endtask

  task automatic t_wrap();
    int errs = 0;
    c_clr = 1; tick(); c_clr = 0;
    for (int i = 0; i < 300; i++) begin c_sv = 1; c_sd = pat(i); tick(); end
    c_sv = 0;
    for (int i = 0; i < 300; i++) begin c_bre = 1; tick(); end
    c_bre = 0;
    for (int i = 0; i < 300; i++) begin c_sv = 1; c_sd = pat(1000 + i); tick(); end
    c_sv = 0;
    check("R8 ptrs before wrapped drain", c_ps, 32'h012C_0258);
    for (int i = 0; i < 300; i++) begin
      c_bre = 1; tick();
      if (c_brd !== pat(1000 + i)) errs++;
    end
    c_bre = 0;
    check("R2 order across address wrap", 32'(errs), 32'h0);
    check("R8 ptrs after wrap", c_ps, 32'h0258_0258);
  endtask

  task automatic t_playback();
    p_bwe = 1; p_bwd = 32'h0000_00A1; tick();
    p_bwd = 32'h0000_00B2; tick();
    p_bwd = 32'h0000_00C3; tick();
    p_bwe = 0;
    check("R11 m_valid with data", {31'h0, p_mv}, 32'h1);
    check("R11 head word", p_md, 32'h0000_00A1);
    p_mr = 1; tick(); p_mr = 0;
    check("R11 next word after handshake", p_md, 32'h0000_00B2);
    check("R8 play ptrs", p_ps, 32'h0001_0003);
    p_sv = 1; p_sd = 32'h5555_5555; p_bre = 1; tick(); p_sv = 0; p_bre = 0;
    check("R10 play ignores stream input", p_ps, 32'h0001_0003);
    check("R10 play bus read zero", p_brd, 32'h0);
    p_mr = 1; tick(); tick(); tick(); p_mr = 0;
    check("R4 play pop on empty holds pointer", p_ps, 32'h0003_0003);
    check("R11 m_valid low after drain", {31'h0, p_mv}, 32'h0);
    for (int i = 0; i < 513; i++) begin p_bwe = 1; p_bwd = pat(i); tick(); end
    p_bwe = 0;
    check("R3 play overflow", {31'h0, p_ovf}, 32'h1);
    check("R3 play ptrs at full", p_ps, 32'h0003_0203);
    check("R11 head after refill", p_md, pat(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_fill_overflow();
    t_drain();
    t_empty_read();
    t_clear();
    t_thresholds();
    t_cap_ignore();
    t_wrap();
    t_playback();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule